// File: doc/BRIEF.md
# Receive Byte Queue with Break Marking

This block holds received characters between a serial deserialiser and a host-side register block. The serial side offers one byte at a time with a valid strobe. The block answers with a ready level that says whether a normal byte can be taken now. A separate single-cycle pulse reports a line break. A break is always recorded, as a zero byte in the queue and as a sticky flag toward the interrupt logic.

The host side removes the oldest byte with a pop strobe. The byte appears on the read data port in the same cycle as the strobe. Two registered flags report the queue: one says data is waiting, the other says the queue is full. The command decoder drives a receiver-enable level and a flush pulse. The interrupt logic clears the break flag with a clear pulse.

Top module: `rxq_break_fifo`

## Requirements
- R1: The queue holds DEPTH bytes (default 4). Bytes leave in the order they arrived.
- R2: `inReady` is high exactly when `rxEnable` is high, `fifoFull` is low and `breakPulse` is low. A byte is stored only in a cycle where `inValid` and `inReady` are both high.
- R3: In the cycle after a push, `rxRdy` is high. `fifoFull` is high exactly while the queue holds DEPTH bytes.
- R4: A `breakPulse` stores a byte of value 0x00 even when the queue is full. When the queue is full, the zero replaces the most recently stored byte and the count stays at DEPTH. A byte offered in the same cycle is not taken.
- R5: A pop on an empty queue shows 0x00 on `popData` and changes no state.
- R6: A pop on a non-empty queue shows the oldest byte on `popData` in the strobe cycle. `fifoFull` is low in the next cycle. `rxRdy` goes low only when the last byte is removed.
- R7: A `flush` empties the queue and clears `rxRdy` and `fifoFull` in the next cycle. It overrides any pop, byte or break byte in the same cycle.
- R8: When a pop and a push fall in the same cycle, the oldest byte leaves first. The new byte is then stored behind the remaining ones, so the count is unchanged.
- R9: `breakFlag` is set in the cycle after a `breakPulse`. It stays set until a `breakClear`. A clear in the same cycle as a break leaves the flag set.
- R10: After reset the queue is empty, `rxRdy`, `fifoFull` and `breakFlag` are low, and `popData` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxEnable | input | 1 | Receiver enable level from the command decoder |
| flush | input | 1 | Empty the queue |
| inByte | input | DATA_W | Received byte |
| inValid | input | 1 | `inByte` is offered this cycle |
| breakPulse | input | 1 | A line break was detected |
| inReady | output | 1 | A normal byte will be taken this cycle |
| popStrobe | input | 1 | Host removes the oldest byte |
| popData | output | DATA_W | Oldest byte, or 0 when empty |
| rxRdy | output | 1 | At least one byte is held |
| fifoFull | output | 1 | DEPTH bytes are held |
| breakFlag | output | 1 | Sticky break indication |
| breakClear | input | 1 | Clears `breakFlag` |

## Verification
The bench uses the default depth of four with eight-bit data. With that size, every fill level from empty to full can be crossed with all 64 combinations of the six control inputs in the same cycle. This covers break-on-full overwrite, pop plus push, flush against every other event, and clear against break. After each combination the bench drains the queue. That drain checks byte order, the last-byte flag edge and the zero returned by an empty pop against a queue model in the bench.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic pop;    // advance the head past the oldest entry
    logic push;   // write one entry
    logic zero;   // written entry is a break marker (0x00)
    logic flush;  // discard all entries
  } rxq_strobe_t;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxEnable,
  input  logic             flush,
  input  logic             inValid,
  input  logic             breakPulse,
  input  logic             popStrobe,
  input  logic             breakClear,
  output logic             inReady,
  output logic             rxRdy,
  output logic             fifoFull,
  output logic             breakFlag,
  output logic             isEmpty,
  output rxq_strobe_t      str,
  output logic [PTR_W-1:0] wrOffset
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] cntAfterPop;
  logic [CNT_W-1:0] countNext;
  logic             accept;
  logic             doPop;

  always_comb begin
    inReady     = rxEnable && !fifoFull && !breakPulse;
    accept      = inValid && inReady;
    doPop       = popStrobe && (count != '0);
    cntAfterPop = count - CNT_W'(doPop);
    str.flush   = flush;
    str.pop     = doPop && !flush;
    str.push    = (accept || breakPulse) && !flush;
    str.zero    = breakPulse;
    if (cntAfterPop == FULL_CNT) wrOffset = PTR_W'(DEPTH - 1);
    else                         wrOffset = cntAfterPop[PTR_W-1:0];
    if (flush)                                    countNext = '0;
    else if (str.push && cntAfterPop != FULL_CNT) countNext = cntAfterPop + 1'b1;
    else                                          countNext = cntAfterPop;
    isEmpty = (count == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      rxRdy     <= 1'b0;
      fifoFull  <= 1'b0;
      breakFlag <= 1'b0;
    end else begin
      count    <= countNext;
      rxRdy    <= (countNext != '0);
      fifoFull <= (countNext == FULL_CNT);
      if (breakPulse)      breakFlag <= 1'b1;
      else if (breakClear) breakFlag <= 1'b0;
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);
  p_full_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull == (count == FULL_CNT));
  p_break_full_r4: assert property (@(posedge clk) disable iff (!rstN)
    (breakPulse && !flush && count == FULL_CNT) |=> (count == FULL_CNT));
  p_empty_pop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (popStrobe && count == '0 && !inValid && !breakPulse) |=> (count == '0));
  p_flush_r7: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (count == '0 && !rxRdy && !fifoFull));
  p_break_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    breakPulse |=> breakFlag);
  p_break_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (breakFlag && !breakClear) |=> breakFlag);
endmodule

// File: rtl/rxq_data.sv
module rxq_data
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8,
  parameter int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxq_strobe_t       str,
  input  logic [PTR_W-1:0]  wrOffset,
  input  logic [DATA_W-1:0] wrByte,
  input  logic              isEmpty,
  output logic [DATA_W-1:0] popData
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  head;
  logic [PTR_W-1:0]  headAfterPop;
  logic [PTR_W-1:0]  wrAddr;

  function automatic logic [PTR_W-1:0] wrapAdd(input logic [PTR_W-1:0] a,
                                               input logic [PTR_W-1:0] b);
    logic [PTR_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= (PTR_W+1)'(DEPTH)) s = s - (PTR_W+1)'(DEPTH);
    return s[PTR_W-1:0];
  endfunction

  always_comb begin
    headAfterPop = str.pop ? wrapAdd(head, PTR_W'(1)) : head;
    wrAddr       = wrapAdd(headAfterPop, wrOffset);
    popData      = isEmpty ? '0 : mem[head];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          head <= '0;
    else if (str.flush) head <= '0;
    else                head <= headAfterPop;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        mem[i] <= '0;
      else if (str.push && wrAddr == PTR_W'(i))
        mem[i] <= str.zero ? '0 : wrByte;
    end
  end

  p_head_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!str.pop && !str.flush) |=> $stable(head));
  p_flush_head_r7: assert property (@(posedge clk) disable iff (!rstN)
    str.flush |=> (head == '0));
endmodule

// File: rtl/rxq_break_fifo.sv
module rxq_break_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic              flush,
  input  logic [DATA_W-1:0] inByte,
  input  logic              inValid,
  input  logic              breakPulse,
  output logic              inReady,
  input  logic              popStrobe,
  output logic [DATA_W-1:0] popData,
  output logic              rxRdy,
  output logic              fifoFull,
  output logic              breakFlag,
  input  logic              breakClear
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  rxq_strobe_t      str;
  logic [PTR_W-1:0] wrOffset;
  logic             isEmpty;

  rxq_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .flush(flush),
    .inValid(inValid), .breakPulse(breakPulse), .popStrobe(popStrobe),
    .breakClear(breakClear), .inReady(inReady), .rxRdy(rxRdy),
    .fifoFull(fifoFull), .breakFlag(breakFlag), .isEmpty(isEmpty),
    .str(str), .wrOffset(wrOffset)
  );

  rxq_data #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_data (
    .clk(clk), .rstN(rstN), .str(str), .wrOffset(wrOffset),
    .wrByte(inByte), .isEmpty(isEmpty), .popData(popData)
  );
endmodule

// File: tb/test_rxq_break_fifo.sv
`timescale 1ns/100ps
module test_rxq_break_fifo;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxEnable = 1'b0, flush = 1'b0, inValid = 1'b0;
  logic       breakPulse = 1'b0, popStrobe = 1'b0, breakClear = 1'b0;
  logic [7:0] inByte = '0;
  logic       inReady, rxRdy, fifoFull, breakFlag;
  logic [7:0] popData;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] mq[$];
  bit mBrk = 0;
  int dataCtr = 0;

  always #2.5 clk = ~clk;

  rxq_break_fifo #(.DEPTH(4), .DATA_W(8)) i_rxq_break_fifo (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .flush(flush),
    .inByte(inByte), .inValid(inValid), .breakPulse(breakPulse),
    .inReady(inReady), .popStrobe(popStrobe), .popData(popData),
    .rxRdy(rxRdy), .fifoFull(fifoFull), .breakFlag(breakFlag),
    .breakClear(breakClear)
  );

  task automatic check(int act, int exp, string req, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // One cycle of stimulus; combinational outputs checked before the edge,
  // registered flags checked just after it, both against the queue model.
  task automatic step(bit pop, bit valid, bit brk, bit fl, bit en, bit clr,
                      string popTag = "");
    logic [7:0] b;
    bit rdy;
    int pre;
    string tag;
    dataCtr++;
    b = {dataCtr[6:0], 1'b1};
    @(negedge clk);
    popStrobe = pop; inValid = valid; breakPulse = brk; flush = fl;
    rxEnable = en; breakClear = clr; inByte = b;
    #1;
    pre = mq.size();
    rdy = en && (pre < 4) && !brk;
    check(inReady, rdy, "R2", "inReady");
    if (pop)
      check(popData, (pre > 0) ? mq[0] : 0,
            (popTag != "") ? popTag : ((pre > 0) ? "R6" : "R5"), "popData");
    tag = fl ? "R7" : brk ? "R4" : (pop && valid) ? "R8" : "R3";
    @(posedge clk);
    if (fl) mq.delete();
    else begin
      if (pop && pre > 0) void'(mq.pop_front());
      if (brk) begin
        if (mq.size() == 4) mq[3] = 8'h00;
        else mq.push_back(8'h00);
      end else if (valid && rdy) mq.push_back(b);
    end
    if (brk) mBrk = 1;
    else if (clr) mBrk = 0;
    #1;
    check(rxRdy, mq.size() > 0, tag, "rxRdy");
    check(fifoFull, mq.size() == 4, tag, "fifoFull");
    check(breakFlag, mBrk, "R9", "breakFlag");
    popStrobe = 0; inValid = 0; breakPulse = 0; flush = 0; breakClear = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    #12 rstN = 1'b1;
    #1;
    // R10: reset state
    check(rxRdy, 0, "R10", "rxRdy");
    check(fifoFull, 0, "R10", "fifoFull");
    check(breakFlag, 0, "R10", "breakFlag");
    check(popData, 0, "R10", "popData");

    // R1: arrival order across a full queue, plus a fifth byte refused
    for (int i = 0; i < 5; i++) step(0, 1, 0, 0, 1, 0);
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 1, 0, "R1");

    // R9: clear together with a break keeps the flag; clear alone drops it
    step(0, 0, 1, 0, 1, 1);
    step(0, 0, 0, 0, 1, 1);
    step(1, 0, 0, 0, 1, 0);

    // Sweep: every fill level crossed with all 64 control combinations
    for (int lvl = 0; lvl <= 4; lvl++) begin
      for (int c = 0; c < 64; c++) begin
        step(0, 0, 0, 1, 1, 1);
        for (int k = 0; k < lvl; k++) step(0, 1, 0, 0, 1, 0);
        step(c[0], c[1], c[2], c[3], c[4], c[5]);
        for (int k = 0; k < 5; k++) step(1, 0, 0, 0, 1, 0);
      end
    end
    finishRun();
  end
endmodule